// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a requester that runs on the chip clock read and write an external asynchronous static RAM of 131,072 bytes. The requester offers one access at a time on a valid/ready port: a write flag, a 17-bit byte address and a data byte. The controller then drives the memory's active-low chip enable, write enable and output enable and its address bus. It also drives the output half of the bidirectional data bus, with a separate drive enable, and reads the input half. A read answers with the byte and a one-cycle valid pulse. A write gives no response.

Two parameters set how long each access lasts: the clock period in nanoseconds and the memory's speed grade, written as its access time (10, 12, 15 or 20 ns). For that grade the matching output-enable times are 5, 6, 7 and 8 ns. These are always shorter than the access time, so the access time alone sets the wait. The controller turns the access time into a count of wait cycles, `WAIT_CYC = max(1, ceil(SPEED_NS / CLK_NS))`.

A read lowers chip enable and output enable together for `WAIT_CYC` cycles and samples the data bus at the end of the last one. A write first drives data for one setup cycle with output enable high. It then lowers write enable for `WAIT_CYC` cycles, so the memory captures the byte as write enable rises. The data stays driven for one hold cycle after that. Every access returns to an idle cycle with all controls high before the next one begins.

Top module: `sramc_top`

## Requirements
- R1: During and right after reset, chip enable, write enable and output enable are high (1). The data drive enable is low, ready is high and the response valid is low.
- R2: A read holds chip enable and output enable low with write enable high for exactly `WAIT_CYC = max(1, ceil(SPEED_NS/CLK_NS))` consecutive cycles.
- R3: Each accepted read produces exactly one single-cycle response pulse. Its data equals the byte most recently written to that address, or 0x00 for an address never written. Responses come back in request order.
- R4: A write holds write enable low for exactly `WAIT_CYC` cycles with chip enable low and output enable high throughout. The data drive enable is high in the cycle before write enable falls, during the whole pulse, and in the cycle after write enable rises. The memory receives the requested byte on that rising edge.
- R5: While chip enable stays low from one cycle to the next, the address bus does not change.
- R6: The data drive enable is never high while output enable is low. Every cycle in which the drive enable turns on is preceded by a cycle with output enable high. This includes a write that immediately follows a read.
- R7: Ready is low for every cycle that chip enable is low. A request presented only while ready is low is ignored and leaves the memory contents unchanged.
- R8: A write produces no response pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller idle; a request is taken on a cycle with valid and ready both high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Byte address |
| reqWdata | input | 8 | Byte to write |
| rspValid | output | 1 | One-cycle pulse with read data |
| rspData | output | 8 | Read data |
| sramCeN | output | 1 | Memory chip enable, active low |
| sramWeN | output | 1 | Memory write enable, active low |
| sramOeN | output | 1 | Memory output enable, active low |
| sramAddr | output | 17 | Memory address bus |
| sramDout | output | 8 | Data bus, driven half |
| sramDoe | output | 1 | Data bus drive enable, active high |
| sramDin | input | 8 | Data bus, received half |

## Verification
The bench builds the controller with a 4 ns clock and the 15 ns grade. That gives a non-integral ratio, so the ceiling rounds up to four wait cycles. The multi-cycle counter, the pulse-length checks and late-valid read data all come into play. The behavioural memory returns the inverse of the stored byte until the last wait cycle of a read, so sampling even one cycle early shows up as a data mismatch. Random mixes of reads and writes over the full address range, including the first and last bytes, put reads directly ahead of writes. That exercises the turnaround cycle on every such pair.

// File: rtl/sramc_pkg.sv
`timescale 1ns/1ps
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD
  } sramc_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture request address and data
    logic sample;     // capture data bus into response register
    logic driveNext;  // data bus drive enable for the coming cycle
  } sramc_strobe_t;

  // wait cycles = max(1, ceil(access / period))
  function automatic int waitCycles(input int accessNs, input int clkNs);
    int q;
    q = (accessNs + clkNs - 1) / clkNs;
    return (q < 1) ? 1 : q;
  endfunction

endpackage

// File: rtl/sramc_ctrl.sv
`timescale 1ns/1ps
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int WAIT_CYC = 2,
  localparam int CNT_W = $clog2(WAIT_CYC + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqWrite,
  output logic          reqReady,
  output sramc_strobe_t strobe,
  output logic          sramCeN,
  output logic          sramWeN,
  output logic          sramOeN
);

  sramc_state_t state, nextState;
  logic [CNT_W-1:0] waitCnt;
  logic lastWait;

  assign lastWait = (waitCnt == '0);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:   if (reqValid) nextState = reqWrite ? ST_WSETUP : ST_READ;
      ST_READ:   if (lastWait) nextState = ST_IDLE;
      ST_WSETUP: nextState = ST_WPULSE;
      ST_WPULSE: if (lastWait) nextState = ST_WHOLD;
      ST_WHOLD:  nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.load      = (state == ST_IDLE) && reqValid;
    strobe.sample    = (state == ST_READ) && lastWait;
    strobe.driveNext = (nextState == ST_WSETUP) || (nextState == ST_WPULSE) ||
                       (nextState == ST_WHOLD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      sramCeN <= 1'b1;
      sramWeN <= 1'b1;
      sramOeN <= 1'b1;
    end else begin
      state <= nextState;
      if ((state != ST_READ && nextState == ST_READ) ||
          (state != ST_WPULSE && nextState == ST_WPULSE))
        waitCnt <= CNT_W'(WAIT_CYC - 1);
      else if (!lastWait)
        waitCnt <= waitCnt - 1'b1;
      sramCeN <= (nextState == ST_IDLE);
      sramWeN <= (nextState != ST_WPULSE);
      sramOeN <= (nextState != ST_READ);
    end
  end

  // run-length counters for the pulse-width checks
  logic [CNT_W-1:0] oeRun, weRun;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      oeRun <= '0;
      weRun <= '0;
    end else begin
      oeRun <= sramOeN ? '0 : oeRun + 1'b1;
      weRun <= sramWeN ? '0 : weRun + 1'b1;
    end
  end

  // R2
  rd_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramOeN) |-> (oeRun == CNT_W'(WAIT_CYC)));

  // R4
  wr_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> (weRun == CNT_W'(WAIT_CYC)));

  // R4
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> (sramOeN && !sramCeN));

  // R7
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sramCeN |-> !reqReady);

endmodule

// File: rtl/sramc_dpath.sv
`timescale 1ns/1ps
module sramc_dpath
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sramc_strobe_t     strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sramDin,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDout,
  output logic              sramDoe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sramAddr <= '0;
      sramDout <= '0;
      sramDoe  <= 1'b0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strobe.load) begin
        sramAddr <= reqAddr;
        sramDout <= reqWdata;
      end
      sramDoe  <= strobe.driveNext;
      rspValid <= strobe.sample;
      if (strobe.sample) rspData <= sramDin;
    end
  end

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R4
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sramDoe && $past(sramDoe)) |-> $stable(sramDout));

endmodule

// File: rtl/sramc_top.sv
`timescale 1ns/1ps
module sramc_top
  import sramc_pkg::*;
#(
  parameter int CLK_NS   = 5,
  parameter int SPEED_NS = 10,
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  localparam int WAIT_CYC = waitCycles(SPEED_NS, CLK_NS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDout,
  output logic              sramDoe,
  input  logic [DATA_W-1:0] sramDin
);

  sramc_strobe_t strobe;

  sramc_ctrl #(.WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .strobe   (strobe),
    .sramCeN  (sramCeN),
    .sramWeN  (sramWeN),
    .sramOeN  (sramOeN)
  );

  sramc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .sramDin  (sramDin),
    .sramAddr (sramAddr),
    .sramDout (sramDout),
    .sramDoe  (sramDoe),
    .rspValid (rspValid),
    .rspData  (rspData)
  );

  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    sramDoe |-> sramOeN);

  // R6
  turnaround_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramDoe) |-> $past(sramOeN));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && $past(!sramCeN)) |-> $stable(sramAddr));

  // R8
  no_write_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    sramDoe |-> !rspValid);

endmodule

// File: tb/sramc_top_bench.sv
`timescale 1ns/1ps
module sramc_top_bench;

  localparam int CLK_PERIOD = 4;
  localparam int SPEED_NS   = 15;
  localparam int EXP_WAIT   = 4;   // ceil(15/4)

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        rspValid;
  logic [7:0]  rspData;
  logic        sramCeN, sramWeN, sramOeN, sramDoe;
  logic [16:0] sramAddr;
  logic [7:0]  sramDout, sramDin;

  always #(CLK_PERIOD/2) clk = ~clk;

  sramc_top #(.CLK_NS(CLK_PERIOD), .SPEED_NS(SPEED_NS)) u_sramc_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .sramCeN(sramCeN),
    .sramWeN(sramWeN), .sramOeN(sramOeN), .sramAddr(sramAddr),
    .sramDout(sramDout), .sramDoe(sramDoe), .sramDin(sramDin)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural memory: data valid only in the last access cycle
  logic [7:0] modelMem [int];
  logic [7:0] modelRdVal = '0;
  int         modelCnt = 0;
  logic       modelDrive;

  assign modelDrive = !sramCeN && !sramOeN && sramWeN;
  assign sramDin = (modelDrive && modelCnt >= EXP_WAIT - 1) ? modelRdVal : ~modelRdVal;

  always @(posedge clk) modelCnt <= modelDrive ? modelCnt + 1 : 0;
  always @(negedge clk)
    modelRdVal = modelMem.exists(int'(sramAddr)) ? modelMem[int'(sramAddr)] : 8'h00;

  always @(posedge sramWeN) if (rstN && !sramCeN) begin
    check(sramDoe, "R4", "data driven at write edge", sramDoe, 1);
    modelMem[int'(sramAddr)] = sramDout;
  end

  // scoreboard
  logic [7:0] shadow [int];
  logic [7:0] expQ [$];
  int rspCount = 0;

  task automatic doReq(input logic wr, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    if (wr) shadow[int'(a)] = d;
    else expQ.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  // monitor and protocol watchers
  logic prevRsp = 1'b0, prevDoe = 1'b0, prevOeN = 1'b1, prevWeN = 1'b1, prevCeN = 1'b1;
  logic [16:0] prevAddr = '0;
  int oeRunB = 0, weRunB = 0;

  always @(negedge clk) if (rstN) begin
    if (rspValid) begin
      rspCount++;
      check(!prevRsp, "R3", "single-cycle response", prevRsp, 0);
      if (expQ.size() == 0) check(1'b0, "R8", "unexpected response", 1, 0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(rspData == e, "R3", "read data", rspData, e);
      end
    end
    if (!sramOeN) oeRunB++;
    else if (oeRunB > 0) begin
      check(oeRunB == EXP_WAIT, "R2", "read strobe length", oeRunB, EXP_WAIT);
      oeRunB = 0;
    end
    if (!sramWeN) begin
      weRunB++;
      check(sramOeN && !sramCeN, "R4", "controls during write pulse",
            {sramOeN, sramCeN}, 2'b10);
      if (prevWeN) check(prevDoe && sramDoe, "R4", "setup drive", {prevDoe, sramDoe}, 2'b11);
    end else if (weRunB > 0) begin
      check(weRunB == EXP_WAIT, "R4", "write pulse length", weRunB, EXP_WAIT);
      check(sramDoe, "R4", "hold drive", sramDoe, 1);
      weRunB = 0;
    end
    if (sramDoe && !sramOeN) check(1'b0, "R6", "drive with output enable low", 1, 0);
    if (sramDoe && !prevDoe)
      check(prevOeN && sramOeN, "R6", "turnaround before drive", {prevOeN, sramOeN}, 2'b11);
    if (!sramCeN) begin
      if (reqReady) check(1'b0, "R7", "ready while busy", 1, 0);
      if (!prevCeN && sramAddr != prevAddr)
        check(1'b0, "R5", "address moved during access", sramAddr, prevAddr);
    end
    prevRsp = rspValid; prevDoe = sramDoe; prevOeN = sramOeN;
    prevWeN = sramWeN;  prevCeN = sramCeN; prevAddr = sramAddr;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "WATCHDOG", "run timed out", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int reads;
    repeat (3) @(negedge clk);
    check({sramCeN, sramWeN, sramOeN} == 3'b111, "R1", "controls in reset",
          {sramCeN, sramWeN, sramOeN}, 3'b111);
    check(!sramDoe && !rspValid, "R1", "drive/rsp in reset", {sramDoe, rspValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({sramCeN, sramWeN, sramOeN, sramDoe} == 4'b1110, "R1", "controls after reset",
          {sramCeN, sramWeN, sramOeN, sramDoe}, 4'b1110);
    check(reqReady && !rspValid, "R1", "ready after reset", {reqReady, rspValid}, 2'b10);

    // R3: unwritten address reads zero
    doReq(1'b0, 17'h00123, 8'h00);
    // R4/R3: edges of the address range
    doReq(1'b1, 17'h00000, 8'h3C);
    doReq(1'b1, 17'h1FFFF, 8'hC3);
    doReq(1'b0, 17'h1FFFF, 8'h00);
    doReq(1'b0, 17'h00000, 8'h00);

    // R3/R4: random fill and readback
    for (int i = 0; i < 64; i++) doReq(1'b1, 17'(i * 2053 + 7), 8'($urandom));
    for (int i = 0; i < 64; i++) doReq(1'b0, 17'(i * 2053 + 7), 8'h00);

    // R6: read immediately followed by write, repeated, mixed random
    for (int i = 0; i < 200; i++) begin
      logic [16:0] a;
      a = 17'($urandom_range(0, 63) * 2053 + 7);
      doReq(1'($urandom_range(0, 1)), a, 8'($urandom));
    end
    for (int i = 0; i < 20; i++) begin
      doReq(1'b0, 17'(i), 8'h00);
      doReq(1'b1, 17'(i), 8'(i + 8'h50));
    end
    for (int i = 0; i < 20; i++) doReq(1'b0, 17'(i), 8'h00);

    // R7: a request offered only while busy is ignored
    doReq(1'b1, 17'h0ABCD, 8'h11);
    doReq(1'b0, 17'h0ABCD, 8'h00);
    @(negedge clk);
    check(!reqReady, "R7", "ready low during read", reqReady, 0);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 17'h0ABCD; reqWdata = 8'hEE;
    @(negedge clk);
    check(!reqReady, "R7", "still busy when request withdrawn", reqReady, 0);
    reqValid = 1'b0;
    doReq(1'b0, 17'h0ABCD, 8'h00);

    // R3: overwrite returns latest byte
    doReq(1'b1, 17'h05555, 8'hA1);
    doReq(1'b1, 17'h05555, 8'hB2);
    doReq(1'b0, 17'h05555, 8'h00);

    repeat (4 * EXP_WAIT + 8) @(negedge clk);
    check(expQ.size() == 0, "R3", "all responses returned", expQ.size(), 0);
    reads = rspCount;
    check(reads > 100, "R8", "response count plausible", reads, 101);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule